// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address by reading a two-level page table from memory. A request carries the virtual address, the kind of access (load, store or instruction fetch), the current privilege, the data-privilege override controls, the two permission-relaxing status bits and the root table page number. The block then issues one page table entry read per level over a simple memory port. It checks the final entry against the access and either returns the physical address with the permissions that can be cached, or reports a page fault.

When an entry has no accessed mark, or a store hits an entry with no dirty mark, the walker writes the updated entry back before it answers. It serves one request at a time. The answer is a one-cycle `done` pulse with registered result fields. Machine-privilege accesses and bare-mode requests bypass the table entirely.

Top module: `pt_walker2`

## Requirements
- R1: The first entry is read at `{req_root, 12'b0} + 4*vaddr[31:22]`. A pointer entry's page number `pte[31:10]` gives the next base as `{ppn, 12'b0}`, and the second entry is read at that base `+ 4*vaddr[21:12]`. A leaf at the second level yields `paddr = {pte[31:10], vaddr[11:0]}`. Entry bits are V=0, R=1, W=2, X=3, U=4, A=6, D=7.
- R2: When the effective privilege is machine (`req_priv` encoding 0=user, 1=supervisor, 3=machine) or `req_paged` is 0, `paddr` is the zero-extended virtual address, all three permissions are set, and no memory read is made.
- R3: For loads and stores (`req_acc` 0=load, 1=store, 2=fetch) at machine privilege with `req_mprv` set, the effective privilege is `req_mpp`. Fetches ignore `req_mprv`.
- R4: An entry with V clear faults. A pointer entry found at the second level, where no level is left, also faults.
- R5: A leaf with W set and R clear is reserved and faults. This covers both W-only and W+X.
- R6: A page with U set faults from any non-user privilege unless `req_sum` is set, and it always faults for a fetch from a non-user privilege. A page with U clear faults from any privilege other than supervisor.
- R7: A load needs R, or X with `req_mxr` set. A store needs W. A fetch needs X.
- R8: A first-level leaf whose `pte[19:10]` is non-zero faults. Otherwise `paddr = {pte[31:20], vaddr[21:12], vaddr[11:0]}`.
- R9: A passing leaf with A clear, or a store to a passing leaf with D clear, is written back with A set (and D set for stores) before `done`. A faulting leaf is never written.
- R10: Reported permissions are `perm_r = R | (X & mxr)`, `perm_x = X` and `perm_w = W & (store | D)`. On a fault, `paddr` and all permissions are zero.
- R11: `done` is high for exactly one cycle per accepted request. `mem_req` is never high on two cycles in a row. Reads return later with `mem_rvalid`, and writes complete in the cycle they are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a translation (sampled when idle) |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| req_mprv | input | 1 | Data accesses use `req_mpp` when at machine privilege |
| req_mpp | input | 2 | Override privilege for data accesses |
| req_sum | input | 1 | Permit supervisor data access to user pages |
| req_mxr | input | 1 | Let execute-only pages be read |
| req_paged | input | 1 | 1 = paged translation, 0 = bare |
| req_root | input | 22 | Root table page number |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 34 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Translation faulted |
| paddr | output | 34 | Physical address |
| perm_r | output | 1 | Readable |
| perm_w | output | 1 | Writable |
| perm_x | output | 1 | Executable |

## Verification
The bench targets the leaf rules one at a time. It covers the two reserved encodings, the user-page cases with and without the relaxing bit, fetch from a user page under that bit, and a supervisor page reached through the data override. A walker that mixed these up would translate where it must fault. The bench also covers an aligned and a misaligned superpage: a wrong merge gives a physical address with the wrong middle bits, and a missing alignment check maps a bad superpage. It checks the entry left in memory after every request, so a missing or spurious accessed/dirty write shows up, as does a writable bit reported for a clean page on a load. It counts memory reads to catch bypass cases that walk anyway and pointer chains that do not stop at the last level.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  // entry bit positions
  localparam int B_V = 0;
  localparam int B_R = 1;
  localparam int B_W = 2;
  localparam int B_X = 3;
  localparam int B_U = 4;
  localparam int B_A = 6;
  localparam int B_D = 7;
  localparam int PPN_LSB = 10;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WAIT, ST_WB, ST_RESP
  } st_e;
endpackage

// File: rtl/ptw_addr.sv
module ptw_addr
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 34,
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  parameter int PTE_W = 32,
  parameter int LVL_W = 1
) (
  input  logic [PA_W-1:0]  base,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PTE_W-1:0] pte,
  output logic [PA_W-1:0]  pte_addr,
  output logic [PA_W-1:0]  paddr,
  output logic             misal
);
  localparam int PPN_W  = PA_W - OFF_W;
  localparam int PTE_SH = $clog2(PTE_W / 8);

  logic [VA_W-1:0]  shifted;
  logic [IDX_W-1:0] idx;
  logic [PPN_W-1:0] ppn, lomask, vpn;

  always_comb begin
    shifted  = vaddr >> (OFF_W + IDX_W * int'(lvl));
    idx      = shifted[IDX_W-1:0];
    pte_addr = base + (PA_W'(idx) << PTE_SH);
    ppn      = pte[PPN_LSB +: PPN_W];
    lomask   = (PPN_W'(1) << (IDX_W * int'(lvl))) - PPN_W'(1);
    vpn      = PPN_W'(vaddr[VA_W-1:OFF_W]);
    misal    = |(ppn & lomask);
    paddr    = {(ppn & ~lomask) | (vpn & lomask), vaddr[OFF_W-1:0]};
  end
endmodule

// File: rtl/ptw_leaf_chk.sv
module ptw_leaf_chk
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       acc,
  input  logic [1:0]       prv,
  input  logic             sum,
  input  logic             mxr,
  input  logic             misal,
  output logic             fault,
  output logic             pr,
  output logic             pw,
  output logic             px,
  output logic             need_wb,
  output logic [PTE_W-1:0] wb_pte
);
  logic is_st, is_ld, is_fe, r, w, x, u, a, d;
  logic rsvd, user_bad, sup_bad, acc_bad;

  always_comb begin
    is_st = (acc == ACC_STORE);
    is_ld = (acc == ACC_LOAD);
    is_fe = !is_st && !is_ld;
    r = pte[B_R]; w = pte[B_W]; x = pte[B_X];
    u = pte[B_U]; a = pte[B_A]; d = pte[B_D];
    rsvd     = w && !r;
    user_bad = u && (prv != PRV_U) && (!sum || is_fe);
    sup_bad  = !u && (prv != PRV_S);
    acc_bad  = (is_ld && !(r || (x && mxr))) || (is_st && !w) || (is_fe && !x);
    fault    = rsvd || user_bad || sup_bad || misal || acc_bad;
    pr       = r || (x && mxr);
    pw       = w && (is_st || d);
    px       = x;
    need_wb  = !a || (is_st && !d);
    wb_pte   = pte;
    wb_pte[B_A] = 1'b1;
    if (is_st) wb_pte[B_D] = 1'b1;
  end
endmodule

// File: rtl/pt_walker2.sv
module pt_walker2
  import ptw_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PA_W   = 34,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PTE_W  = 32,
  parameter int LEVELS = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic [1:0]              req_acc,
  input  logic [1:0]              req_priv,
  input  logic                    req_mprv,
  input  logic [1:0]              req_mpp,
  input  logic                    req_sum,
  input  logic                    req_mxr,
  input  logic                    req_paged,
  input  logic [PA_W-OFF_W-1:0]   req_root,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [PA_W-1:0]         mem_addr,
  output logic [PTE_W-1:0]        mem_wdata,
  input  logic                    mem_rvalid,
  input  logic [PTE_W-1:0]        mem_rdata,
  output logic                    done,
  output logic                    fault,
  output logic [PA_W-1:0]         paddr,
  output logic                    perm_r,
  output logic                    perm_w,
  output logic                    perm_x
);
  localparam int PPN_W = PA_W - OFF_W;
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  st_e              st;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q, prv_q;
  logic             sum_q, mxr_q, fault_q, pr_q, pw_q, px_q;
  logic [PA_W-1:0]  base_q, ptea_q, paddr_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PTE_W-1:0] pte_q;

  logic [1:0]       eff_prv;
  logic [PA_W-1:0]  pte_addr_c, leaf_pa;
  logic             misal, chk_fault, c_pr, c_pw, c_px, need_wb;
  logic [PTE_W-1:0] wb_pte;
  logic             is_ptr;

  ptw_addr #(.VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W),
             .PTE_W(PTE_W), .LVL_W(LVL_W)) u_addr (
    .base(base_q), .vaddr(va_q), .lvl(lvl_q), .pte(mem_rdata),
    .pte_addr(pte_addr_c), .paddr(leaf_pa), .misal(misal)
  );

  ptw_leaf_chk #(.PTE_W(PTE_W)) u_chk (
    .pte(mem_rdata), .acc(acc_q), .prv(prv_q), .sum(sum_q), .mxr(mxr_q),
    .misal(misal), .fault(chk_fault), .pr(c_pr), .pw(c_pw), .px(c_px),
    .need_wb(need_wb), .wb_pte(wb_pte)
  );

  always_comb begin
    eff_prv = (req_priv == PRV_M && req_acc != ACC_FETCH && req_mprv) ? req_mpp : req_priv;
    is_ptr  = !mem_rdata[B_R] && !mem_rdata[B_W] && !mem_rdata[B_X];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      va_q <= '0; acc_q <= '0; prv_q <= '0; sum_q <= 1'b0; mxr_q <= 1'b0;
      base_q <= '0; ptea_q <= '0; lvl_q <= '0; pte_q <= '0;
      fault_q <= 1'b0; paddr_q <= '0; pr_q <= 1'b0; pw_q <= 1'b0; px_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          va_q <= req_vaddr; acc_q <= req_acc; prv_q <= eff_prv;
          sum_q <= req_sum; mxr_q <= req_mxr; fault_q <= 1'b0;
          if (eff_prv == PRV_M || !req_paged) begin
            paddr_q <= PA_W'(req_vaddr);
            {pr_q, pw_q, px_q} <= 3'b111;
            st <= ST_RESP;
          end else begin
            base_q <= {req_root, {OFF_W{1'b0}}};
            lvl_q  <= LVL_W'(LEVELS - 1);
            st     <= ST_RD;
          end
        end
        ST_RD: begin
          ptea_q <= pte_addr_c;
          st     <= ST_WAIT;
        end
        ST_WAIT: if (mem_rvalid) begin
          if (!mem_rdata[B_V] || (is_ptr && lvl_q == '0) || (!is_ptr && chk_fault)) begin
            fault_q <= 1'b1; paddr_q <= '0;
            {pr_q, pw_q, px_q} <= 3'b000;
            st <= ST_RESP;
          end else if (is_ptr) begin
            base_q <= {mem_rdata[PPN_LSB +: PPN_W], {OFF_W{1'b0}}};
            lvl_q  <= lvl_q - LVL_W'(1);
            st     <= ST_RD;
          end else begin
            paddr_q <= leaf_pa;
            {pr_q, pw_q, px_q} <= {c_pr, c_pw, c_px};
            pte_q <= wb_pte;
            st <= need_wb ? ST_WB : ST_RESP;
          end
        end
        ST_WB:   st <= ST_RESP;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (st == ST_RD) || (st == ST_WB);
    mem_we    = (st == ST_WB);
    mem_addr  = (st == ST_WB) ? ptea_q : pte_addr_c;
    mem_wdata = pte_q;
    done      = (st == ST_RESP);
    fault     = fault_q;
    paddr     = paddr_q;
    perm_r    = pr_q;
    perm_w    = pw_q;
    perm_x    = px_q;
  end

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r11_single_access: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req);
  a_r10_fault_clean: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (paddr == '0 && !perm_r && !perm_w && !perm_x));
  a_r9_wb_sets_a: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> mem_wdata[B_A]);
  a_r9_wb_then_ok: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |=> (done && !fault));
endmodule

// File: tb/sim_pt_walker2.sv
module sim_pt_walker2;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0, req_priv = '0, req_mpp = '0;
  logic        req_mprv = 1'b0, req_sum = 1'b0, req_mxr = 1'b0, req_paged = 1'b0;
  logic [21:0] req_root = 22'd1;
  logic        mem_req, mem_we, mem_rvalid = 1'b0;
  logic [33:0] mem_addr, paddr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic        done, fault, perm_r, perm_w, perm_x;

  pt_walker2 u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_priv(req_priv), .req_mprv(req_mprv), .req_mpp(req_mpp),
    .req_sum(req_sum), .req_mxr(req_mxr), .req_paged(req_paged), .req_root(req_root),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .paddr(paddr), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x)
  );

  // memory model: 16 KB, reads answered one cycle after the request cycle
  logic [31:0] mem [0:4095];
  logic        pend = 1'b0;
  logic [11:0] raddr = '0;
  int          nrd = 0;

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (pend) begin
      mem_rvalid = 1'b1;
      mem_rdata  = mem[raddr];
      pend       = 1'b0;
    end
    if (mem_req && !mem_we) begin
      pend  = 1'b1;
      raddr = mem_addr[13:2];
      nrd++;
    end
    if (mem_req && mem_we) mem[mem_addr[13:2]] = mem_wdata;
  end

  typedef struct packed {
    logic [31:0] va;  logic [1:0] acc; logic [1:0] prv; logic mprv; logic [1:0] mpp;
    logic sum; logic mxr; logic paged; logic [31:0] l1; logic [31:0] l2;
    logic xf; logic [33:0] xpa; logic [2:0] xrwx; logic [31:0] xwb; logic [1:0] xrd;
    logic [7:0] rq;
  } vec_t;

  localparam logic [31:0] VA = 32'h00403ABC;
  localparam logic [31:0] VB = 32'hFFC01234;
  localparam logic [31:0] PT = 32'h00000801;
  localparam int NV = 25;
  localparam vec_t VT [NV] = '{
    '{VA,2'd0,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D14C3,1'b0,34'h012345ABC,3'b100,32'h048D14C3,2'd2,8'd1}, // R1
    '{VB,2'd1,2'd0,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D1457,1'b0,34'h012345234,3'b110,32'h048D14D7,2'd2,8'd9}, // R9 store sets A,D
    '{VA,2'd0,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D1403,1'b0,34'h012345ABC,3'b100,32'h048D1443,2'd2,8'd9}, // R9 load sets A
    '{VA,2'd0,2'd0,1'b0,2'd0,1'b0,1'b1,1'b1,PT,32'h048D1459,1'b0,34'h012345ABC,3'b101,32'h048D1459,2'd2,8'd7}, // R7 X+MXR read
    '{VA,2'd0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D1459,1'b1,34'h0,3'b000,32'h048D1459,2'd2,8'd7},         // R7 no MXR
    '{VA,2'd2,2'd1,1'b0,2'd0,1'b1,1'b0,1'b1,PT,32'h048D1459,1'b1,34'h0,3'b000,32'h048D1459,2'd2,8'd6},         // R6 fetch user page
    '{VA,2'd0,2'd1,1'b0,2'd0,1'b1,1'b0,1'b1,PT,32'h048D1453,1'b0,34'h012345ABC,3'b100,32'h048D1453,2'd2,8'd6}, // R6 SUM
    '{VA,2'd0,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D1453,1'b1,34'h0,3'b000,32'h048D1453,2'd2,8'd6},         // R6 no SUM
    '{VA,2'd0,2'd0,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D1443,1'b1,34'h0,3'b000,32'h048D1443,2'd2,8'd6},         // R6 user on sup page
    '{VA,2'd1,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D1445,1'b1,34'h0,3'b000,32'h048D1445,2'd2,8'd5},         // R5 W only
    '{VA,2'd2,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D144D,1'b1,34'h0,3'b000,32'h048D144D,2'd2,8'd5},         // R5 W+X
    '{VA,2'd0,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D1442,1'b1,34'h0,3'b000,32'h048D1442,2'd2,8'd4},         // R4 V clear at L2
    '{VA,2'd0,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,32'h0,32'h048D14C3,1'b1,34'h0,3'b000,32'h048D14C3,2'd1,8'd4},      // R4 V clear at L1
    '{VA,2'd0,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,PT,PT,1'b1,34'h0,3'b000,PT,2'd2,8'd4},                             // R4 out of levels
    '{VA,2'd0,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,32'h04B000CB,32'h0,1'b0,34'h012C03ABC,3'b101,32'h04B000CB,2'd1,8'd8}, // R8 superpage
    '{VA,2'd0,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,32'h04B004CB,32'h0,1'b1,34'h0,3'b000,32'h04B004CB,2'd1,8'd8},      // R8 misaligned
    '{VA,2'd1,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D14C7,1'b0,34'h012345ABC,3'b110,32'h048D14C7,2'd2,8'd10}, // R10 store W
    '{VA,2'd0,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D1447,1'b0,34'h012345ABC,3'b100,32'h048D1447,2'd2,8'd10}, // R10 clean hides W
    '{VA,2'd0,2'd3,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D14C3,1'b0,34'h000403ABC,3'b111,32'h048D14C3,2'd0,8'd2}, // R2 machine
    '{VA,2'd0,2'd1,1'b0,2'd0,1'b0,1'b0,1'b0,PT,32'h048D14C3,1'b0,34'h000403ABC,3'b111,32'h048D14C3,2'd0,8'd2}, // R2 bare
    '{VA,2'd0,2'd3,1'b1,2'd1,1'b0,1'b0,1'b1,PT,32'h048D14C3,1'b0,34'h012345ABC,3'b100,32'h048D14C3,2'd2,8'd3}, // R3 override to S
    '{VA,2'd2,2'd3,1'b1,2'd1,1'b0,1'b0,1'b1,PT,32'h048D14C3,1'b0,34'h000403ABC,3'b111,32'h048D14C3,2'd0,8'd3}, // R3 fetch ignores
    '{VA,2'd1,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D14C3,1'b1,34'h0,3'b000,32'h048D14C3,2'd2,8'd7},         // R7 store needs W
    '{VA,2'd2,2'd1,1'b0,2'd0,1'b0,1'b0,1'b1,PT,32'h048D14CB,1'b0,34'h012345ABC,3'b101,32'h048D14CB,2'd2,8'd7}, // R7 fetch X
    '{VA,2'd0,2'd3,1'b1,2'd0,1'b0,1'b0,1'b1,PT,32'h048D14C3,1'b1,34'h0,3'b000,32'h048D14C3,2'd2,8'd3}          // R3 override to U
  };

  int nchk = 0, nfail = 0;

  task automatic chk(input string what, input int rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R11 watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    vec_t v;
    int s1, s2, ls, t;
    for (int k = 0; k < 4096; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("reset done", 11, 64'(done), 64'd0);
    chk("reset mem_req", 11, 64'(mem_req), 64'd0);

    for (int i = 0; i < NV; i++) begin
      v  = VT[i];
      s1 = 1024 + int'(v.va[31:22]);
      s2 = 2048 + int'(v.va[21:12]);
      mem[s1] = v.l1;
      mem[s2] = v.l2;
      ls = (v.l1[0] && v.l1[3:1] != 3'b000) ? s1 : s2;
      nrd = 0;
      @(negedge clk);
      req_vaddr = v.va; req_acc = v.acc; req_priv = v.prv; req_mprv = v.mprv;
      req_mpp = v.mpp; req_sum = v.sum; req_mxr = v.mxr; req_paged = v.paged;
      req_root = 22'd1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!done && t < 50) begin
        @(negedge clk);
        t++;
      end
      chk($sformatf("v%0d done seen", i), 11, 64'(done), 64'd1);
      chk($sformatf("v%0d fault", i), int'(v.rq), 64'(fault), 64'(v.xf));
      chk($sformatf("v%0d paddr", i), int'(v.rq), 64'(paddr), 64'(v.xpa));
      chk($sformatf("v%0d rwx", i), int'(v.rq), 64'({perm_r, perm_w, perm_x}), 64'(v.xrwx));
      chk($sformatf("v%0d reads", i), int'(v.rq), 64'(nrd), 64'(v.xrd));
      chk($sformatf("v%0d leaf in memory (R9)", i), int'(v.rq), 64'(mem[ls]), 64'(v.xwb));
      @(negedge clk);
      chk($sformatf("v%0d done one cycle", i), 11, 64'(done), 64'd0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule